// File: doc/BRIEF.md
# Double-Buffered Reference Divider

This block divides a reference clock by a programmable ratio and emits a one-cycle comparison pulse at the end of every count, for use by a phase/frequency detector. A new ratio arrives on a parallel input with a load strobe. It is first held in a staging register. It moves into the working divider only at the counter's own reload point, so a count that has already started always finishes with the ratio it started with. Ratio changes therefore land on a period boundary, where they can line up with changes to other dividers.

Only ratios of 1 and of 5 up to the top of the 13-bit range are accepted. A load of 0, 2, 3 or 4 raises an error flag and changes nothing else. A second, independent path drives a reference output pin from a four-stage binary prescaler. A select input chooses the output: held low, the raw clock, or the clock divided by 2, 4, 8 or 16.

Top module: `ref_ratio_divider`

## Requirements
- R1: During and after reset, frPulse and ratioErr are 0 and the working ratio is RESET_RATIO (default 5). The first frPulse appears on the RESET_RATIO-th rising edge after reset is released.
- R2: frPulse is high for exactly one cycle per count. With working ratio N, consecutive pulses are N cycles apart.
- R3: With a working ratio of 1, frPulse is high on every cycle.
- R4: A legal ratio loaded in the middle of a count does not shorten or lengthen that count. It becomes the working ratio at the next reload, and the count after that lasts exactly the new ratio.
- R5: A load of 0, 2, 3 or 4 sets ratioErr on the next cycle. It leaves the working ratio and any staged ratio unchanged.
- R6: A load of a legal ratio (1, or 5 to 8191) clears ratioErr on the next cycle.
- R7: When several legal loads occur before a reload, only the last one is transferred.
- R8: A load on the same clock edge as a reload is not used by that reload. It takes effect at the following reload.
- R9: refOutSel selects refOut as follows. 0 holds it low. 1 passes the clock through. 2, 3, 4 and 5 give the clock divided by 2, 4, 8 and 16, taken from a binary counter that is cleared by reset and steps on every rising edge. 6 and 7 hold it low.
- R10: The largest ratio, 8191, gives pulses exactly 8191 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStb | input | 1 | Single-cycle strobe that stages ratioIn |
| ratioIn | input | 13 | New divide ratio |
| refOutSel | input | 3 | Reference output mode select |
| frPulse | output | 1 | Comparison-frequency pulse, one cycle per count |
| ratioErr | output | 1 | Last load carried an unsupported ratio |
| refOut | output | 1 | Prescaled reference output |

## Verification
frPulse is registered. It rises one edge after the counter reaches zero, and with working ratio N it repeats every N edges. ratioErr follows a load strobe by one edge. A ratio staged before a reload edge shows up in the spacing of the pulse that edge produces. The divided refOut taps follow the number of edges since reset, while the pass-through tap is combinational. The bench drives inputs on falling edges and steps a behavioural model on each rising edge. It compares every output 2 ns after that edge, while the clock is still high, so a pass-through refOut reads 1 and each registered output holds the value due for the cycle that just began.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic reload;  // counter at terminal count, reload on this edge
    logic swap;    // a staged ratio is waiting and moves in on this reload
  } divStrobe_t;

  // Ratios 0, 2, 3 and 4 are unsupported
  function automatic logic ratioLegal(input int unsigned value);
    return (value == 1) || (value >= 5);
  endfunction

endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import refdiv_pkg::*;
#(
  parameter int RATIO_W = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadStb,
  input  logic [RATIO_W-1:0] ratioIn,
  input  logic               terminal,
  output divStrobe_t         strobe,
  output logic [RATIO_W-1:0] pendRatio,
  output logic               ratioErr
);

  logic pendValid;
  logic loadLegal;

  assign loadLegal = ratioLegal(int'(ratioIn));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendRatio <= '0;
      ratioErr  <= 1'b0;
    end else begin
      // A reload consumes the staged ratio
      if (terminal) pendValid <= 1'b0;
      if (loadStb) begin
        if (loadLegal) begin
          pendRatio <= ratioIn;
          pendValid <= 1'b1;  // a load on the same edge is kept for the next reload
          ratioErr  <= 1'b0;
        end else begin
          ratioErr  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.reload = terminal;
    strobe.swap   = terminal & pendValid;
  end

endmodule

// File: rtl/refdiv_count.sv
module refdiv_count
  import refdiv_pkg::*;
#(
  parameter int RATIO_W     = 13,
  parameter int RESET_RATIO = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrobe_t         strobe,
  input  logic [RATIO_W-1:0] pendRatio,
  output logic               terminal,
  output logic               frPulse,
  output logic [RATIO_W-1:0] activeRatio
);

  localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(RESET_RATIO);
  localparam logic [RATIO_W-1:0] RST_CNT   = RATIO_W'(RESET_RATIO - 1);

  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] nextRatio;

  assign terminal  = (cnt == '0);
  assign nextRatio = strobe.swap ? pendRatio : activeRatio;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeRatio <= RST_RATIO;
      cnt         <= RST_CNT;
      frPulse     <= 1'b0;
    end else begin
      frPulse <= strobe.reload;
      if (strobe.reload) begin
        activeRatio <= nextRatio;
        cnt         <= nextRatio - 1'b1;
      end else begin
        cnt         <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/refdiv_outpre.sv
module refdiv_outpre #(
  parameter int STAGES = 4,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] refOutSel,
  output logic             refOut
);

  localparam int NTAP = 2 ** SEL_W;

  logic [STAGES-1:0] divCnt;
  logic [NTAP-1:0]   tapVec;

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  // Tap 0: low, tap 1: clock, taps 2..STAGES+1: counter bits, rest: low
  for (genvar g = 0; g < NTAP; g++) begin : gTap
    if (g == 0) begin : gLow
      assign tapVec[g] = 1'b0;
    end else if (g == 1) begin : gPass
      assign tapVec[g] = clk;
    end else if (g < STAGES + 2) begin : gDiv
      assign tapVec[g] = divCnt[g-2];
    end else begin : gSpare
      assign tapVec[g] = 1'b0;
    end
  end

  assign refOut = tapVec[refOutSel];

endmodule

// File: rtl/ref_ratio_divider.sv
module ref_ratio_divider
  import refdiv_pkg::*;
#(
  parameter int RATIO_W     = 13,
  parameter int RESET_RATIO = 5,
  parameter int OUT_STAGES  = 4,
  parameter int OUT_SEL_W   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadStb,
  input  logic [RATIO_W-1:0]   ratioIn,
  input  logic [OUT_SEL_W-1:0] refOutSel,
  output logic                 frPulse,
  output logic                 ratioErr,
  output logic                 refOut
);

  divStrobe_t         strobe;
  logic               terminal;
  logic [RATIO_W-1:0] pendRatio;
  logic [RATIO_W-1:0] activeRatio;

  refdiv_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .ratioIn(ratioIn),
    .terminal(terminal), .strobe(strobe), .pendRatio(pendRatio),
    .ratioErr(ratioErr)
  );

  refdiv_count #(.RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pendRatio(pendRatio),
    .terminal(terminal), .frPulse(frPulse), .activeRatio(activeRatio)
  );

  refdiv_outpre #(.STAGES(OUT_STAGES), .SEL_W(OUT_SEL_W)) u_outpre (
    .clk(clk), .rstN(rstN), .refOutSel(refOutSel), .refOut(refOut)
  );

endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker
  import refdiv_pkg::*;
#(
  parameter int RATIO_W   = 13,
  parameter int OUT_SEL_W = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 loadStb,
  input logic [RATIO_W-1:0]   ratioIn,
  input logic [OUT_SEL_W-1:0] refOutSel,
  input logic                 frPulse,
  input logic                 ratioErr,
  input logic                 refOut,
  input logic [RATIO_W-1:0]   activeRatio
);

  // R2: one-cycle pulse unless the working ratio is 1
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (frPulse && activeRatio != 1) |=> !frPulse);

  // R3: ratio 1 keeps the pulse high
  a_r3_every_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (frPulse && activeRatio == 1) |=> frPulse);

  // R4: the working ratio moves only on a reload edge
  a_r4_swap_on_reload: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeRatio) |-> frPulse);

  // R5: unsupported load raises the flag
  a_r5_flag_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !ratioLegal(int'(ratioIn))) |=> ratioErr);

  // R5: the working ratio never holds an unsupported value
  a_r5_active_legal: assert property (@(posedge clk) disable iff (!rstN)
    ratioLegal(int'(activeRatio)));

  // R6: supported load clears the flag
  a_r6_clear_legal: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && ratioLegal(int'(ratioIn))) |=> !ratioErr);

  // R9: select 0 holds the output low
  a_r9_static_low: assert property (@(posedge clk) disable iff (!rstN)
    (refOutSel == 0) |-> !refOut);

endmodule

bind ref_ratio_divider refdiv_checker #(.RATIO_W(RATIO_W), .OUT_SEL_W(OUT_SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadStb(loadStb), .ratioIn(ratioIn),
  .refOutSel(refOutSel), .frPulse(frPulse), .ratioErr(ratioErr),
  .refOut(refOut), .activeRatio(activeRatio)
);

// File: tb/ref_ratio_divider_tb.sv
module ref_ratio_divider_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStb = 1'b0;
  logic [12:0] ratioIn = '0;
  logic [2:0]  refOutSel = 3'd0;
  logic        frPulse, ratioErr, refOut;

  int nVec = 0;
  int nFail = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // behavioural model state
  int mAct, mCnt, mPend, mTick;
  bit mPendV, mErr, expFr;

  always #5 clk = ~clk;

  ref_ratio_divider u_dut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .ratioIn(ratioIn),
    .refOutSel(refOutSel), .frPulse(frPulse), .ratioErr(ratioErr),
    .refOut(refOut)
  );

  function automatic bit legalRatio(int r);
    return (r == 1) || (r >= 5);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mAct = 5; mCnt = 4; mPend = 0; mPendV = 0; mErr = 0; mTick = 0; expFr = 0;
    end else begin
      expFr = (mCnt == 0);
      if (mCnt == 0) begin
        if (mPendV) mAct = mPend;
        mPendV = 0;
        mCnt = mAct - 1;
      end else begin
        mCnt = mCnt - 1;
      end
      if (loadStb) begin
        if (legalRatio(int'(ratioIn))) begin
          mPend = int'(ratioIn); mPendV = 1; mErr = 0;
        end else begin
          mErr = 1;
        end
      end
      mTick = mTick + 1;
    end
  end

  function automatic bit expRefOut(int sel, int tick);
    case (sel)
      1: return 1'b1;               // sampled while the clock is high
      2: return tick[0];
      3: return tick[1];
      4: return tick[2];
      5: return tick[3];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string what, logic act, logic exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      if (!rstN) begin
        check("reset frPulse", frPulse, 1'b0);   // R1
        check("reset ratioErr", ratioErr, 1'b0); // R1
      end else begin
        check("frPulse", frPulse, expFr);
        check("ratioErr", ratioErr, mErr);
        check("refOut", refOut, expRefOut(int'(refOutSel), mTick));
      end
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadRatio(int r);
    @(negedge clk);
    loadStb = 1'b1; ratioIn = 13'(r);
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  initial begin
    curReq = "R1";
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(12);                 // R1 first pulse, R2 spacing at ratio 5
    curReq = "R2";
    waitCyc(10);
    curReq = "R4";               // R4 load mid-count
    waitCyc(2);
    loadRatio(7);
    waitCyc(30);
    curReq = "R5";               // R5 unsupported values
    loadRatio(3);
    waitCyc(5);
    loadRatio(0);
    loadRatio(2);
    loadRatio(4);
    waitCyc(20);
    curReq = "R6";
    loadRatio(9);
    waitCyc(25);
    curReq = "R7";               // R7 last staged wins
    loadRatio(6);
    loadRatio(11);
    waitCyc(40);
    curReq = "R8";               // R8 load on the reload edge
    @(negedge clk);
    while (mCnt != 0) @(negedge clk);
    loadStb = 1'b1; ratioIn = 13'd13;
    @(negedge clk);
    loadStb = 1'b0;
    waitCyc(40);
    curReq = "R3";
    loadRatio(1);
    waitCyc(30);
    loadRatio(5);
    waitCyc(15);
    curReq = "R9";
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      refOutSel = 3'(s);
      waitCyc(40);
    end
    refOutSel = 3'd3;
    curReq = "R10";
    loadRatio(8191);
    waitCyc(8191 * 2 + 20);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    #2_000_000;
    nFail++;
    done = 1'b1;
    $display("FAIL watchdog %s: actual running expected finished", curReq);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule